// File: doc/BRIEF.md
# Step-Paced Pulse Width Modulator

This block drives one pulse-width-modulated output whose timebase is a stream of single-cycle step pulses from a neighbouring timer, not the clock. An 8-bit phase counter moves forward by one on each step while the function is enabled. Every 256 steps form one period. The output is high while the phase is below the active width, so a width of W gives W high steps out of 256.

Software sets the width by writing a code into a holding register. The code is forced into the legal range 1 to 254. The active width is taken from the holding register only when a new period begins, either at the wrap from phase 255 to 0 or while the function is disabled, so a period in progress is never cut short or stretched. While disabled, the output is held low and the phase is held at 0. On enable, a fresh period starts at once with the most recently written width.

Top module: `pwm_step_gen`

## Requirements
- R1: After reset the output is low, the phase is 0 and the active width is 1, so the first enabled period has exactly 1 high step.
- R2: With enable high, each cycle with step high advances the phase by one. The phase wraps from 255 to 0, so one period is 256 steps.
- R3: A cycle with step low leaves the phase, and so the output, unchanged.
- R4: The output is high exactly when enable is high and the phase (0..255) is below the active width. A width of 3 gives 3 high steps per 256-step period.
- R5: A written code of 0 becomes width 1 and a code of 255 becomes width 254. Codes 1 to 254 are kept as written.
- R6: A write during a period does not change the remainder of that period. It takes effect from the next period.
- R7: A write in the same cycle as the step that wraps the phase from 255 to 0 applies to the period that starts with that wrap. When several writes come before a period starts, the last one is used.
- R8: While enable is low, the output is low and the phase is held at 0. Writes are still accepted, and once enable rises the period starts at phase 0 with the latest written width.

Top module ports in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Function enable; low forces the output low and the phase to 0 |
| step | input | 1 | One-cycle timeout pulse from the pacing timer |
| wr_en | input | 1 | Width write strobe |
| wr_code | input | 8 | Width code to be written |
| pwm_out | output | 1 | Modulated output |

## Verification
The width write and the period wrap are the two functions that can fall in the same cycle. The bench drives a write together with the step that moves the phase from 255 to 0, both in directed cases and through random writes over long runs. It then judges the result by counting the high steps of the period that follows, which must equal the newly written width after clamping. It also counts a mid-period write against the old width for the rest of that period, so the decision about which width applies is seen at the pin.

// File: rtl/pwm_step_pkg.sv
package pwm_step_pkg;
  // Reason the active width register is being refreshed from the holding value
  typedef enum logic [1:0] {
    LOAD_NONE = 2'd0,
    LOAD_IDLE = 2'd1,
    LOAD_WRAP = 2'd2
  } load_src_t;
endpackage

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  output logic [W-1:0] phase,
  output logic         cycle_wrap
);
  localparam logic [W-1:0] LAST = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  assign cycle_wrap = en & step & (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= '0;
    else if (!en)    phase <= '0;
    else if (step)   phase <= phase + ONE;
  end
endmodule

// File: rtl/pwm_width_hold.sv
module pwm_width_hold
  import pwm_step_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cycle_wrap,
  input  logic         wr_en,
  input  logic [W-1:0] wr_code,
  output logic [W-1:0] act_w
);
  localparam logic [W-1:0] TOPC = '1;
  localparam logic [W-1:0] MINW = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAXW = TOPC - MINW;

  function automatic logic [W-1:0] legal_width(input logic [W-1:0] code);
    if (code == '0)   return MINW;
    if (code == TOPC) return MAXW;
    return code;
  endfunction

  logic [W-1:0] hold_w;
  logic [W-1:0] next_hold;
  load_src_t    load_src;

  always_comb begin
    next_hold = wr_en ? legal_width(wr_code) : hold_w;
    if (!en)             load_src = LOAD_IDLE;
    else if (cycle_wrap) load_src = LOAD_WRAP;
    else                 load_src = LOAD_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_w <= MINW;
      act_w  <= MINW;
    end else begin
      hold_w <= next_hold;
      if (load_src != LOAD_NONE) act_w <= next_hold;
    end
  end
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  logic [W-1:0] phase,
  input  logic [W-1:0] act_w,
  output logic         pulse
);
  function automatic logic in_pulse(input logic [W-1:0] ph, input logic [W-1:0] wd);
    return ph < wd;
  endfunction

  assign pulse = en & in_pulse(phase, act_w);
endmodule

// File: rtl/pwm_step_gen.sv
module pwm_step_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic         wr_en,
  input  logic [W-1:0] wr_code,
  output logic         pwm_out
);
  logic [W-1:0] phase;
  logic [W-1:0] act_w;
  logic         cycle_wrap;

  pwm_phase_ctr #(.W(W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step),
    .phase(phase), .cycle_wrap(cycle_wrap)
  );

  pwm_width_hold #(.W(W)) u_width (
    .clk(clk), .rst_n(rst_n), .en(en), .cycle_wrap(cycle_wrap),
    .wr_en(wr_en), .wr_code(wr_code), .act_w(act_w)
  );

  pwm_duty_cmp #(.W(W)) u_cmp (
    .en(en), .phase(phase), .act_w(act_w), .pulse(pwm_out)
  );
endmodule

// File: rtl/pwm_step_chk.sv
module pwm_step_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         step,
  input logic         wr_en,
  input logic [W-1:0] phase,
  input logic [W-1:0] act_w,
  input logic         cycle_wrap,
  input logic         pwm_out
);
  localparam logic [W-1:0] TOPC = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  assert_idle_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == '0));

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step) |=> (!en || phase == $past(phase) + ONE || phase == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> (!en || $stable(phase)));

  assert_width_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_w != '0) && (act_w != TOPC));

  assert_width_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cycle_wrap) |=> $stable(act_w));

  assert_first_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase == '0) |-> pwm_out);

  assert_last_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase == TOPC) |-> !pwm_out);

  assert_wrap_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_wrap |-> (step && en && !wr_en) || (step && en && wr_en));
endmodule

bind pwm_step_gen pwm_step_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .step(step), .wr_en(wr_en),
  .phase(phase), .act_w(act_w), .cycle_wrap(cycle_wrap), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_step_gen.sv
`timescale 1ns/1ps
module tb_pwm_step_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       step = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_code = 8'd0;
  logic       pwm_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench reference state
  int ref_ph = 0;
  int ref_act = 1;
  int ref_hold = 1;
  int highs = 0;

  always #2 clk = ~clk;

  pwm_step_gen #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step),
    .wr_en(wr_en), .wr_code(wr_code), .pwm_out(pwm_out)
  );

  function automatic int expect_width(input int code);
    if (code <= 0) return 1;
    if (code >= 255) return 254;
    return code;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // One cycle: drive after the falling edge, update reference at the rising
  // edge, compare the pin at the next falling edge.
  task automatic tick(input bit e, input bit s, input bit w, input int c);
    int nh;
    bit wrap;
    en = e; step = s; wr_en = w; wr_code = c[7:0];
    #1;
    if (e && s) highs += int'(pwm_out);
    @(posedge clk);
    nh   = w ? expect_width(c) : ref_hold;
    wrap = e && s && (ref_ph == 255);
    if (!e) ref_ph = 0;
    else if (s) ref_ph = (ref_ph + 1) % 256;
    if (!e || wrap) ref_act = nh;
    ref_hold = nh;
    @(negedge clk);
    chk("R4 pin vs phase/width", int'(pwm_out), int'(e && (ref_ph < ref_act)));
  endtask

  // Step through one full period from phase 0, counting high steps.
  task automatic period(input string req, input int exp_highs);
    highs = 0;
    for (int i = 0; i < 256; i++) tick(1'b1, 1'b1, 1'b0, 0);
    chk(req, highs, exp_highs);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 low in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 low after reset", int'(pwm_out), 0);
    tick(1'b1, 1'b0, 1'b0, 0);
    chk("R1 high at phase 0", int'(pwm_out), 1);
    tick(1'b0, 1'b0, 1'b0, 0);
    tick(1'b1, 1'b0, 1'b0, 0);
    period("R1 default width 1", 1);

    // R3: no step keeps output
    tick(1'b1, 1'b1, 1'b0, 0);
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 1'b0, 0);
    chk("R3 held low without steps", int'(pwm_out), 0);

    // R5 clamps, R8 write while disabled
    tick(1'b0, 1'b0, 1'b1, 0);
    chk("R8 low while disabled", int'(pwm_out), 0);
    tick(1'b1, 1'b0, 1'b0, 0);
    period("R5 code 0 gives 1", 1);
    tick(1'b0, 1'b0, 1'b1, 255);
    tick(1'b1, 1'b0, 1'b0, 0);
    period("R5 code 255 gives 254", 254);
    tick(1'b0, 1'b0, 1'b1, 3);
    tick(1'b1, 1'b0, 1'b0, 0);
    period("R4 width 3 example", 3);
    tick(1'b0, 1'b0, 1'b1, 254);
    tick(1'b1, 1'b0, 1'b0, 0);
    period("R5 code 254 kept", 254);

    // R6: mid-period write is deferred
    tick(1'b0, 1'b0, 1'b1, 3);
    tick(1'b1, 1'b0, 1'b0, 0);
    highs = 0;
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, 1'b0, 0);
    tick(1'b1, 1'b0, 1'b1, 200);
    for (int i = 0; i < 246; i++) tick(1'b1, 1'b1, 1'b0, 0);
    chk("R6 current period keeps old width", highs, 3);
    period("R6 next period uses new width", 200);

    // R7: write coincident with wrap step, last write wins
    highs = 0;
    for (int i = 0; i < 250; i++) tick(1'b1, 1'b1, 1'b0, 0);
    tick(1'b1, 1'b0, 1'b1, 17);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b0, 0);
    tick(1'b1, 1'b1, 1'b1, 60);
    chk("R7 pin right after wrap", int'(pwm_out), 1);
    period("R7 write at wrap applies now", 60);

    // R8: disable mid-pulse, enable restarts at phase 0
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b0, 0);
    tick(1'b0, 1'b1, 1'b0, 0);
    chk("R8 forced low", int'(pwm_out), 0);
    tick(1'b0, 1'b1, 1'b1, 9);
    tick(1'b1, 1'b0, 1'b0, 0);
    period("R8 restart with latest width", 9);

    // R2: exact period length with wrap
    tick(1'b0, 1'b0, 1'b1, 128);
    tick(1'b1, 1'b0, 1'b0, 0);
    period("R2 256-step period", 128);
    period("R2 repeats after wrap", 128);

    // random mix, reference compared each cycle
    for (int i = 0; i < 30000; i++) begin
      tick(($urandom % 16) != 0, ($urandom % 2) == 1,
           ($urandom % 40) == 0, int'($urandom % 256));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule